// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block keeps a small, fully associative set of segment descriptors for an address translation unit. Each slot holds two 64-bit words. The tag word carries the effective segment number and a valid flag. The attribute word carries the virtual segment number, a segment-size code, protection keys, a no-execute flag, a class flag and a page-size code. A single request port accepts one operation per cycle, and the result comes back on the following cycle. The operations are:

- lookup by effective address;
- guarded store into a slot;
- raw read of either word of a slot;
- find, which returns the attribute word or all ones;
- removal of the segment that covers an address;
- bulk removal steered by a 3-bit hint.

Each entry is tried against two segment sizes in parallel. A 256 MB segment compares address bits 63:28. A 1 TB segment compares bits 63:40, and its tag must hold zeros in bits 39:28. The entry's own size code decides which of the two comparisons counts. Removing a segment by address raises a one-cycle flush strobe, so the translation cache next to this block can drop stale pages. Bulk removal has hint values that choose whether slot 0 is spared and whether entries of class 0 are kept, and these choices depend on a mode input.

Top module: `seg_lookaside`

## Requirements
- R1: After reset every slot reads back zero in both words, and no lookup hits.
- R2: The op code is req_op: 0 lookup, 1 store, 2 read tag, 3 read attribute, 4 find, 5 remove-local, 6 remove-global, 7 remove-all.
  - Every accepted request produces rsp_valid exactly one cycle later, and idle cycles produce none.
  - The tag word holds the segment number in [63:28], the valid flag in bit 27, and zeros in [26:0].
  - The attribute word holds the size code in [63:62] (00 = 256 MB, 01 = 1 TB), the class flag in bit 7, and the page-size code {bit 8, bits 5:4}.
  - A lookup hits an entry whose size code is 00 and whose tag equals {addr[63:28], 1, 27'b0}.
  - A lookup also hits an entry whose size code is 01 and whose tag equals {addr[63:40], 12'b0, 1, 27'b0}.
  - On a hit, the lookup returns rsp_hit, the slot number and the attribute word. On a miss, it returns rsp_hit low and data zero.
- R3: When several entries match, the lowest-numbered one is returned.
- R4: A store takes the slot from req_a[11:0], the tag from req_a with bits 11:0 cleared, and the attribute word from req_b. It is rejected with rsp_err if any of these holds:
  - the slot is at or above ENTRIES;
  - any of req_a[26:12] is set;
  - the size code is 10 or 11.
- R5: A store is also rejected in either of these cases:
  - it asks for a 1 TB segment while en_1t is low;
  - its page-size code is not enabled in PGSZ_OK (default: codes 0, 4 and 5).
- R6: A read of the tag or the attribute word returns that word from slot req_a[11:0]. If the slot is out of range, the read raises rsp_err with data zero.
- R7: Find returns the hitting attribute word, or all ones on a miss. When mode64 is low, find clears address bits 63:32 before matching. Lookup never clears them.
- R8: Remove-local and remove-global clear the valid flag of the hitting entry. On a hit they raise flush_local or flush_global, respectively, together with the response. On a miss, nothing changes and no strobe is raised.
- R9: Remove-all uses hint req_a[2:0]. With isa_v3 low, every hint behaves the same. With isa_v3 high, hints 0, 1, 2, 5 and 6 behave the same way. In all of these cases, slots 1 and up are invalidated and slot 0 is kept.
- R10: With isa_v3 high, the remaining hints behave as follows:
  - hint 7 invalidates nothing;
  - hint 4 invalidates every slot, including slot 0;
  - hint 3 invalidates every slot whose class flag is 1 and keeps those with class 0.
- R11: A rejected store leaves both words of every slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_a | input | 64 | Address, slot/tag operand or hint |
| req_b | input | 64 | Attribute word for a store |
| mode64 | input | 1 | 64-bit addressing for find |
| en_1t | input | 1 | 1 TB segments allowed |
| isa_v3 | input | 1 | Newest hint decoding |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Illegal request |
| rsp_hit | output | 1 | Associative match found |
| rsp_data | output | 64 | Returned word |
| rsp_idx | output | $clog2(ENTRIES) | Slot number of the hit |
| flush_local | output | 1 | Local translation flush strobe |
| flush_global | output | 1 | Global translation flush strobe |

## Verification
The bench builds the block with ENTRIES = 8 and the default page-size mask. With only eight slots, a single sweep fills every entry, so each bulk-removal hint can be observed on every slot, including slot 0. The small size also makes out-of-range slots start at 8, which lets the bench test rejection just above the limit and at the 12-bit maximum of 4095. With duplicate tags in low and high slots, the priority rule and the fall-through after a removal become visible.

// File: rtl/seg_lookaside.sv
module seg_lookaside #(
  parameter int         ENTRIES = 32,
  parameter logic [7:0] PGSZ_OK = 8'b0011_0001
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [2:0]                            req_op,
  input  logic [63:0]                           req_a,
  input  logic [63:0]                           req_b,
  input  logic                                  mode64,
  input  logic                                  en_1t,
  input  logic                                  isa_v3,
  output logic                                  rsp_valid,
  output logic                                  rsp_err,
  output logic                                  rsp_hit,
  output logic [63:0]                           rsp_data,
  output logic [((ENTRIES>1)?$clog2(ENTRIES):1)-1:0] rsp_idx,
  output logic                                  flush_local,
  output logic                                  flush_global
);
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int VBIT = 27;
  localparam int CBIT = 7;
  localparam logic [2:0] OP_LOOKUP = 3'd0, OP_STORE = 3'd1, OP_RD_TAG = 3'd2,
                         OP_RD_ATTR = 3'd3, OP_FIND = 3'd4, OP_RM_LOC = 3'd5,
                         OP_RM_GLB = 3'd6, OP_RM_ALL = 3'd7;

  logic [63:0] tag_q  [ENTRIES];
  logic [63:0] attr_q [ENTRIES];

  logic [63:0]        srch_a, key_s, key_t;
  logic [ENTRIES-1:0] hit_v, kill_v;
  logic [IW-1:0]      hit_idx, sidx;
  logic               any_hit, slot_ok, st_bad;
  logic [11:0]        slot;
  logic [2:0]         hint, pg;
  logic               spare0, rm_none, keep_c0;

  assign srch_a  = (req_op == OP_FIND && !mode64) ? {32'b0, req_a[31:0]} : req_a;
  assign key_s   = {srch_a[63:28], 1'b1, 27'b0};
  assign key_t   = {srch_a[63:40], 12'b0, 1'b1, 27'b0};
  assign slot    = req_a[11:0];
  assign sidx    = slot[IW-1:0];
  assign slot_ok = {20'b0, slot} < 32'(ENTRIES);
  assign pg      = {req_b[8], req_b[5:4]};
  assign st_bad  = !slot_ok || (|req_a[26:12]) || req_b[63] ||
                   (req_b[63:62] == 2'b01 && !en_1t) || !PGSZ_OK[pg];
  assign hint    = req_a[2:0];
  assign rm_none = isa_v3 && hint == 3'd7;
  assign spare0  = !(isa_v3 && (hint == 3'd3 || hint == 3'd4));
  assign keep_c0 = isa_v3 && hint == 3'd3;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hit_v[g]  = (tag_q[g] == key_s && attr_q[g][63:62] == 2'b00) ||
                       (tag_q[g] == key_t && attr_q[g][63:62] == 2'b01);
    assign kill_v[g] = !rm_none && (g != 0 || !spare0) && !(keep_c0 && !attr_q[g][CBIT]);
  end

  assign any_hit = |hit_v;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_v[i]) hit_idx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        attr_q[i] <= '0;
      end
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_data     <= '0;
      rsp_idx      <= '0;
      flush_local  <= 1'b0;
      flush_global <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_err      <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_data     <= '0;
      rsp_idx      <= '0;
      flush_local  <= 1'b0;
      flush_global <= 1'b0;
      if (req_valid) begin
        case (req_op)
          OP_LOOKUP, OP_FIND: begin
            rsp_hit  <= any_hit;
            rsp_idx  <= any_hit ? hit_idx : '0;
            rsp_data <= any_hit ? attr_q[hit_idx] : (req_op == OP_FIND ? '1 : '0);
          end
          OP_STORE: begin
            if (st_bad) rsp_err <= 1'b1;
            else begin
              tag_q[sidx]  <= {req_a[63:12], 12'b0};
              attr_q[sidx] <= req_b;
            end
          end
          OP_RD_TAG, OP_RD_ATTR: begin
            if (!slot_ok) rsp_err <= 1'b1;
            else rsp_data <= (req_op == OP_RD_TAG) ? tag_q[sidx] : attr_q[sidx];
          end
          OP_RM_LOC, OP_RM_GLB: begin
            if (any_hit) begin
              tag_q[hit_idx][VBIT] <= 1'b0;
              rsp_hit      <= 1'b1;
              rsp_idx      <= hit_idx;
              flush_local  <= (req_op == OP_RM_LOC);
              flush_global <= (req_op == OP_RM_GLB);
            end
          end
          default: begin
            for (int i = 0; i < ENTRIES; i++)
              if (kill_v[i]) tag_q[i][VBIT] <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_IDLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_local && flush_global)); // R8
  AST_FLUSH_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local || flush_global) |-> (rsp_valid && rsp_hit)); // R8
  AST_STORE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_STORE && {20'b0, req_a[11:0]} >= 32'(ENTRIES)) |=> rsp_err); // R4
  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_RD_TAG || req_op == OP_RD_ATTR) &&
     {20'b0, req_a[11:0]} >= 32'(ENTRIES)) |=> (rsp_err && rsp_data == '0)); // R6
  AST_FIND_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_FIND && !any_hit) |=> (rsp_data == '1)); // R7
  AST_SLOT0_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_RM_ALL && spare0) |=> (tag_q[0][VBIT] == $past(tag_q[0][VBIT]))); // R9
endmodule

// File: tb/seg_lookaside_tb.sv
module seg_lookaside_tb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mode64 = 1, en_1t = 1, isa_v3 = 0;
  logic [2:0] req_op = 0;
  logic [63:0] req_a = 0, req_b = 0;
  logic rsp_valid, rsp_err, rsp_hit, flush_local, flush_global;
  logic [63:0] rsp_data;
  logic [2:0] rsp_idx;
  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] m_t [N];
  logic [63:0] m_v [N];

  always #4 clk = ~clk;

  seg_lookaside #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_a(req_a),
    .req_b(req_b), .mode64(mode64), .en_1t(en_1t), .isa_v3(isa_v3), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_idx(rsp_idx),
    .flush_local(flush_local), .flush_global(flush_global));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] mk_e(input logic [35:0] seg, input logic [11:0] s);
    return {seg, 1'b1, 15'b0, s};
  endfunction
  function automatic logic [63:0] mk_e1t(input logic [23:0] seg, input logic [11:0] s);
    return {seg, 12'b0, 1'b1, 15'b0, s};
  endfunction
  function automatic logic [63:0] mk_v(input logic [1:0] sz, input logic [2:0] pg,
                                       input logic cls, input logic [31:0] id);
    return {sz, 18'b0, id, 3'b0, pg[2], cls, 1'b0, pg[1:0], 4'b0};
  endfunction

  function automatic int m_find(input logic [63:0] a);
    for (int i = 0; i < N; i++) begin
      if (m_t[i][27] && m_t[i][26:0] == 0) begin
        if (m_v[i][63:62] == 2'b00 && m_t[i][63:28] == a[63:28]) return i;
        if (m_v[i][63:62] == 2'b01 && m_t[i][63:40] == a[63:40] && m_t[i][39:28] == 0) return i;
      end
    end
    return -1;
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    logic e_err, e_hit, e_fl, e_fg;
    logic [63:0] e_data, sa;
    int e_idx, s, h, first;
    logic [2:0] pg;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || flush_local !== 1'b0 || flush_global !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle cycle: got v=%b fl=%b fg=%b expected 0 0 0",
               rsp_valid, flush_local, flush_global);
    end
    req_valid = 1; req_op = op; req_a = a; req_b = b;
    e_err = 0; e_hit = 0; e_fl = 0; e_fg = 0; e_data = 0; e_idx = 0;
    s = int'(a[11:0]);
    case (op)
      3'd0, 3'd4: begin
        sa = (op == 3'd4 && !mode64) ? {32'b0, a[31:0]} : a;
        h = m_find(sa);
        if (h >= 0) begin e_hit = 1; e_idx = h; e_data = m_v[h]; end
        else e_data = (op == 3'd4) ? '1 : '0;
      end
      3'd1: begin
        pg = {b[8], b[5:4]};
        if (s >= N || (|a[26:12]) || b[63] || (b[63:62] == 2'b01 && !en_1t) ||
            !(pg == 0 || pg == 4 || pg == 5)) e_err = 1;
        else begin m_t[s] = {a[63:12], 12'b0}; m_v[s] = b; end
      end
      3'd2, 3'd3: begin
        if (s >= N) e_err = 1;
        else e_data = (op == 3'd2) ? m_t[s] : m_v[s];
      end
      3'd5, 3'd6: begin
        h = m_find(a);
        if (h >= 0) begin
          m_t[h][27] = 0; e_hit = 1; e_idx = h;
          e_fl = (op == 3'd5); e_fg = (op == 3'd6);
        end
      end
      default: begin
        h = int'(a[2:0]);
        first = (isa_v3 && (h == 3 || h == 4)) ? 0 : 1;
        if (!(isa_v3 && h == 7))
          for (int i = first; i < N; i++)
            if (!(isa_v3 && h == 3 && m_v[i][7] == 0)) m_t[i][27] = 0;
      end
    endcase
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_err !== e_err || rsp_hit !== e_hit || flush_local !== e_fl ||
        flush_global !== e_fg || rsp_data !== e_data || (e_hit && rsp_idx !== 3'(e_idx))) begin
      errors++;
      $display("FAIL %s: got v%b e%b h%b fl%b fg%b idx%0d data %h expected v1 e%b h%b fl%b fg%b idx%0d data %h",
               tag, rsp_valid, rsp_err, rsp_hit, flush_local, flush_global, rsp_idx, rsp_data,
               e_err, e_hit, e_fl, e_fg, e_idx, e_data);
    end
    req_valid = 0;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < N; i++) begin
      do_op(3'd2, 64'(i), 0, tag);
      do_op(3'd3, 64'(i), 0, tag);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < N; i++)
      do_op(3'd1, mk_e(36'h0_0100_0000 + 36'(i), 12'(i)),
            mk_v(2'b00, 3'd0, i[0], 32'h100 + 32'(i)), "R2 fill store");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_t[i] = 0; m_v[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1 reset contents");
    do_op(3'd0, 64'h0, 0, "R1 lookup after reset");
    // R2 256 MB and 1 TB matching
    do_op(3'd1, mk_e(36'h1_2345_6789, 12'd2), mk_v(2'b00, 3'd0, 0, 32'hAAAA), "R2 store 256M");
    do_op(3'd0, {36'h1_2345_6789, 28'h0ABCDEF}, 0, "R2 lookup 256M hit");
    do_op(3'd0, {36'h1_2345_6788, 28'h0ABCDEF}, 0, "R2 lookup 256M miss");
    do_op(3'd1, mk_e1t(24'hABCDEF, 12'd5), mk_v(2'b01, 3'd4, 1, 32'hBBBB), "R2 store 1T");
    do_op(3'd0, {24'hABCDEF, 40'h12_3456_789A}, 0, "R2 lookup 1T hit");
    do_op(3'd1, mk_e1t(24'h111111, 12'd6), mk_v(2'b00, 3'd5, 0, 32'hCCCC), "R2 store 1T-form tag sized 256M");
    do_op(3'd0, {24'h111111, 12'h001, 28'h5}, 0, "R2 size code mismatch misses");
    do_op(3'd0, {24'h111111, 12'h000, 28'h5}, 0, "R2 256M match on zero middle bits");
    // R3 priority
    do_op(3'd1, mk_e(36'h7_7777_7777, 12'd4), mk_v(2'b00, 3'd0, 0, 32'h4444), "R3 store high dup");
    do_op(3'd1, mk_e(36'h7_7777_7777, 12'd1), mk_v(2'b00, 3'd0, 0, 32'h1111), "R3 store low dup");
    do_op(3'd0, {36'h7_7777_7777, 28'h1}, 0, "R3 lowest slot wins");
    do_op(3'd5, {36'h7_7777_7777, 28'h2}, 0, "R8 remove-local hit");
    do_op(3'd0, {36'h7_7777_7777, 28'h1}, 0, "R3 next duplicate after removal");
    do_op(3'd6, {36'h7_7777_7777, 28'h3}, 0, "R8 remove-global hit");
    do_op(3'd6, {36'h7_7777_7777, 28'h3}, 0, "R8 remove miss no strobe");
    do_op(3'd2, 64'd4, 0, "R8 valid flag cleared");
    // R4 / R11 store rejection
    do_op(3'd1, mk_e(36'h5, 12'd8), mk_v(2'b00, 3'd0, 0, 1), "R4 slot just out of range");
    do_op(3'd1, mk_e(36'h5, 12'd4095), mk_v(2'b00, 3'd0, 0, 1), "R4 slot max");
    do_op(3'd1, mk_e(36'h5, 12'd2) | 64'h0010_0000, mk_v(2'b00, 3'd0, 0, 1), "R4 reserved tag bit");
    do_op(3'd1, mk_e(36'h5, 12'd2), mk_v(2'b10, 3'd0, 0, 1), "R4 size code 10");
    do_op(3'd1, mk_e(36'h5, 12'd2), mk_v(2'b11, 3'd0, 0, 1), "R4 size code 11");
    do_op(3'd2, 64'd2, 0, "R11 tag unchanged after rejects");
    do_op(3'd3, 64'd2, 0, "R11 attr unchanged after rejects");
    // R5
    en_1t = 0;
    do_op(3'd1, mk_e1t(24'h222222, 12'd3), mk_v(2'b01, 3'd0, 0, 2), "R5 1T disabled");
    en_1t = 1;
    do_op(3'd1, mk_e(36'h6, 12'd3), mk_v(2'b00, 3'd1, 0, 2), "R5 page code 1 rejected");
    do_op(3'd1, mk_e(36'h6, 12'd3), mk_v(2'b00, 3'd7, 0, 2), "R5 page code 7 rejected");
    do_op(3'd3, 64'd3, 0, "R11 slot 3 untouched");
    // R6
    do_op(3'd3, 64'd5, 0, "R6 read attr");
    do_op(3'd2, 64'd9, 0, "R6 read tag out of range");
    do_op(3'd3, 64'hFFF, 0, "R6 read attr out of range");
    // R7
    do_op(3'd1, mk_e(36'h0_0000_0003, 12'd3), mk_v(2'b00, 3'd4, 1, 32'h3333), "R7 store low seg");
    do_op(3'd4, 64'hDEAD_BEEF_3000_0000, 0, "R7 find 64-bit miss");
    mode64 = 0;
    do_op(3'd4, 64'hDEAD_BEEF_3000_0000, 0, "R7 find 32-bit clears high bits");
    do_op(3'd0, 64'hDEAD_BEEF_3000_0000, 0, "R7 lookup does not clear");
    mode64 = 1;
    do_op(3'd4, {36'h1_2345_6789, 28'h0}, 0, "R7 find hit");
    // R9 legacy
    fill();
    do_op(3'd7, 64'd3, 0, "R9 legacy hint 3");
    sweep("R9 after legacy remove-all");
    fill();
    isa_v3 = 1;
    do_op(3'd7, 64'd0, 0, "R9 hint 0");
    sweep("R9 after hint 0");
    fill();
    do_op(3'd7, 64'd5, 0, "R9 hint 5");
    sweep("R9 after hint 5");
    fill();
    do_op(3'd7, 64'd6, 0, "R9 hint 6");
    do_op(3'd2, 64'd0, 0, "R9 slot 0 kept");
    // R10
    fill();
    do_op(3'd7, 64'd7, 0, "R10 hint 7");
    sweep("R10 after hint 7");
    do_op(3'd7, 64'd3, 0, "R10 hint 3");
    sweep("R10 after hint 3");
    fill();
    do_op(3'd7, 64'd4, 0, "R10 hint 4");
    sweep("R10 after hint 4");
    do_op(3'd0, {36'h0_0100_0000, 28'h0}, 0, "R10 slot 0 gone");
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule